// File: doc/BRIEF.md
# Upset-Tolerant Serial Key Detector

This block watches a serial bit stream and raises a pulse each time a fixed 16-bit key has arrived, most significant bit first. It is built as a 16-state machine. State k means that the first k bits of the key have arrived in order. Every input is synchronous to the block clock. A bit is consumed only on cycles where its valid strobe is high.

The state register is five bits wide. It holds the four-bit state number and one extra bit that makes the parity of the whole code even. Any two legal codes therefore differ in at least two positions. A single flipped register bit always produces an odd-parity code. That code is flagged and can never stand in for another state, so a single upset cannot cause a false match. On the clock after an odd-parity code appears, the machine returns to the idle code.

A fault mask input is XORed into the next code ahead of the register, so upsets can be injected on purpose. With the mask at zero, the block behaves as a plain key detector.

Top module: `d2_key_detector`

## Requirements
- R1: Reset is synchronous and active high. It loads the idle code 5'b00000, which is state 0. After reset is released, both outputs are low.
- R2: The state code is {k[3:0], p}. Here k is the number of key bits matched so far, and p is the XOR of the bits of k, so the parity over all five bits is even. Key bit j (j counting from 0 in arrival order) is KEY[15-j].
- R3: In a legal state k below 15, a valid bit equal to KEY[15-k] moves the machine to state k+1.
- R4: While bit_valid is low, a legal state is kept unchanged and no match is produced.
- R5: In a legal state, a valid bit that differs from the expected key bit moves the machine to state 1 if the bit equals KEY[15], and to state 0 otherwise.
- R6: match_o is high for the one cycle that follows a clock edge at which the state is 15, bit_valid is high and bit_in equals KEY[0]. That same edge returns the machine to state 0, so matches do not overlap.
- R7: When the register holds an odd-parity code, the next edge sets illegal_o high for one cycle and loads the idle code, whatever the inputs are. No match is produced from such a code.
- R8: fault_mask is XORed into the next code before it is registered, and mask bit p flips code bit p (bit 0 is the parity bit). A mask with one bit set always yields an odd-parity code, which R7 then flags. A two-bit mask can land on another legal code without being flagged.
- R9: With fault_mask held at zero, the output sequence equals that of an unprotected detector that follows R3 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | High when bit_in carries a bit to consume |
| fault_mask | input | 5 | Per-bit upset injection, XORed into the next code |
| match_o | output | 1 | One-cycle pulse when the full key has arrived |
| illegal_o | output | 1 | One-cycle pulse when the register held an odd-parity code |

## Verification
Both outputs are registered. A match or a bad-code flag is visible in the cycle after the edge that samples the deciding bit or code. A mask applied at one edge is therefore flagged two edges later: the first edge stores the corrupted code, and the second edge reports it. The bench drives inputs on the falling edge. On the next falling edge, it compares both outputs with a behavioural model that it advanced by one step for those same inputs. The directed checks for faults insert the extra idle step so that they sample at the cycle where the flag is due.

// File: rtl/d2_pkg.sv
package d2_pkg;

    // Key length; the state number must fill its field exactly, so keep it a power of two.
    localparam int KEY_W  = 16;
    localparam int IDX_W  = $clog2(KEY_W);
    localparam int CODE_W = IDX_W + 1;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t state;
        logic  match;
        logic  illegal;
    } det_regs_t;

    // State number in the upper bits, even-parity bit at position 0.
    function automatic code_t make_code(input idx_t k);
        return {k, ^k};
    endfunction

    function automatic logic code_legal(input code_t c);
        return ~(^c);
    endfunction

endpackage

// File: rtl/d2_code_check.sv
module d2_code_check
    import d2_pkg::*;
(
    input  code_t code_i,
    output idx_t  idx_o,
    output logic  legal_o
);

    assign idx_o   = code_i[CODE_W-1:1];
    assign legal_o = code_legal(code_i);

endmodule

// File: rtl/d2_code_gen.sv
module d2_code_gen
    import d2_pkg::*;
(
    input  idx_t  idx_i,
    output code_t code_o
);

    assign code_o = make_code(idx_i);

endmodule

// File: rtl/d2_step_logic.sv
module d2_step_logic
    import d2_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 16'hB3C5
) (
    input  idx_t idx_i,
    input  logic legal_i,
    input  logic bit_i,
    input  logic valid_i,
    output idx_t next_idx_o,
    output logic hit_o
);

    localparam idx_t LAST = idx_t'(KEY_W - 1);
    localparam idx_t ONE  = idx_t'(1);

    // Key bits in arrival order: position j is the bit expected in state j.
    logic [KEY_W-1:0] key_seq;
    for (genvar j = 0; j < KEY_W; j++) begin : g_key
        assign key_seq[j] = KEY[KEY_W-1-j];
    end

    logic want_bit;
    logic bit_ok;

    always_comb begin
        want_bit   = key_seq[idx_i];
        bit_ok     = (bit_i == want_bit);
        hit_o      = 1'b0;
        next_idx_o = idx_i;
        if (!legal_i) begin
            next_idx_o = '0;
        end else if (valid_i) begin
            if (bit_ok) begin
                if (idx_i == LAST) begin
                    hit_o      = 1'b1;
                    next_idx_o = '0;
                end else begin
                    next_idx_o = idx_i + ONE;
                end
            end else begin
                next_idx_o = (bit_i == key_seq[0]) ? ONE : '0;
            end
        end
    end

endmodule

// File: rtl/d2_key_detector.sv
module d2_key_detector
    import d2_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 16'hB3C5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_valid,
    input  logic [CODE_W-1:0] fault_mask,
    output logic              match_o,
    output logic              illegal_o
);

    det_regs_t r_d, r_q;

    idx_t  cur_idx;
    logic  cur_ok;
    idx_t  nxt_idx;
    logic  hit;
    code_t nxt_code;

    d2_code_check u_check (
        .code_i  (r_q.state),
        .idx_o   (cur_idx),
        .legal_o (cur_ok)
    );

    d2_step_logic #(.KEY(KEY)) u_step (
        .idx_i      (cur_idx),
        .legal_i    (cur_ok),
        .bit_i      (bit_in),
        .valid_i    (bit_valid),
        .next_idx_o (nxt_idx),
        .hit_o      (hit)
    );

    d2_code_gen u_gen (
        .idx_i  (nxt_idx),
        .code_o (nxt_code)
    );

    always_comb begin
        r_d         = r_q;
        r_d.state   = nxt_code ^ fault_mask;
        r_d.match   = hit;
        r_d.illegal = ~cur_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign match_o   = r_q.match;
    assign illegal_o = r_q.illegal;

    // R7
    flag_after_bad_chk: assert property (@(posedge clk) disable iff (rst)
        !cur_ok |=> illegal_o);

    // R7
    bad_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cur_ok && fault_mask == '0) |=> (r_q.state == '0));

    // R6
    match_needs_legal_chk: assert property (@(posedge clk) disable iff (rst)
        match_o |-> $past(cur_ok && bit_valid));

    // R6
    match_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && fault_mask == '0) |=> (r_q.state == '0));

    // R8
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(fault_mask) == 1 && code_legal(nxt_code)) |=> !cur_ok);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && cur_ok && fault_mask == '0) |=> $stable(r_q.state));

    // R2
    stay_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_mask == '0) |=> cur_ok);

endmodule

// File: tb/d2_key_detector_test.sv
`timescale 1ns/1ps
module d2_key_detector_test;

    localparam logic [15:0] KEY = 16'hB3C5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic [4:0] fault_mask = '0;
    logic       match_o;
    logic       illegal_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string tag = "R1";

    // Model state: five-bit code and the outputs due after the next edge.
    logic [4:0] m_code = '0;
    logic       e_m = 1'b0;
    logic       e_i = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    d2_key_detector #(.KEY(KEY)) uut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
        .fault_mask(fault_mask), .match_o(match_o), .illegal_o(illegal_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string what, input logic got, input logic exp);
        checks = checks + 1;
        if (got !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%b expected=%b", what, got, exp);
        end
    endtask

    task automatic model(input logic din, input logic vld, input logic [4:0] mask);
        int k;
        logic ok;
        logic [3:0] nk;
        ok  = (^m_code) == 1'b0;
        k   = int'(m_code[4:1]);
        e_m = 1'b0;
        e_i = !ok;
        nk  = m_code[4:1];
        if (!ok) nk = 4'd0;
        else if (vld) begin
            if (din == KEY[15-k]) begin
                if (k == 15) begin e_m = 1'b1; nk = 4'd0; end
                else nk = 4'(k + 1);
            end else begin
                nk = (din == KEY[15]) ? 4'd1 : 4'd0;
            end
        end
        m_code = {nk, ^nk} ^ mask;
    endtask

    task automatic step(input logic din, input logic vld, input logic [4:0] mask);
        @(negedge clk);
        check({tag, " match_o per cycle"}, match_o, e_m);
        check({tag, " illegal_o per cycle"}, illegal_o, e_i);
        bit_in = din;
        bit_valid = vld;
        fault_mask = mask;
        model(din, vld, mask);
    endtask

    task automatic idle_expect(input string what, input logic m, input logic i);
        step(1'b0, 1'b0, 5'b0);
        check({what, " match"}, match_o, m);
        check({what, " illegal"}, illegal_o, i);
    endtask

    task automatic send_bits(input int from, input int upto);
        for (int j = from; j <= upto; j++) step(KEY[15-j], 1'b1, 5'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset match", match_o, 1'b0);
        check("R1 reset illegal", illegal_o, 1'b0);

        // R1/R3: a full key right after reset matches on its last bit
        tag = "R3";
        send_bits(0, 15);
        idle_expect("R3 full key after reset", 1'b1, 1'b0);
        idle_expect("R6 pulse lasts one cycle", 1'b0, 1'b0);

        // R6: back-to-back keys both match
        tag = "R6";
        send_bits(0, 15);
        send_bits(0, 15);
        idle_expect("R6 second key of pair", 1'b1, 1'b0);

        // R4: gaps with wrong bits while valid is low
        tag = "R4";
        for (int j = 0; j < 16; j++) begin
            step(~KEY[15-j], 1'b0, 5'b0);
            step(KEY[15-j], 1'b1, 5'b0);
        end
        idle_expect("R4 key with invalid gaps", 1'b1, 1'b0);

        // R5: mismatch equal to first key bit restarts at state 1
        tag = "R5";
        for (int k = 1; k < 16; k++) begin
            if (KEY[15-k] != KEY[15]) begin
                send_bits(0, k - 1);
                step(~KEY[15-k], 1'b1, 5'b0);
                send_bits(1, 15);
                idle_expect("R5 restart at state one", 1'b1, 1'b0);
                break;
            end
        end
        // R5: mismatch differing from first key bit restarts at state 0
        for (int k = 1; k < 16; k++) begin
            if (KEY[15-k] == KEY[15]) begin
                send_bits(0, k - 1);
                step(~KEY[15-k], 1'b1, 5'b0);
                send_bits(1, 15);
                idle_expect("R5 restart at state zero", 1'b0, 1'b0);
                break;
            end
        end

        // R8/R7: each single-bit flip is flagged, then recovery
        tag = "R8";
        for (int p = 0; p < 5; p++) begin
            send_bits(0, p + 2);
            step(1'b0, 1'b0, 5'(1 << p));
            step(1'b0, 1'b0, 5'b0);
            idle_expect("R8 single flip flagged", 1'b0, 1'b1);
            tag = "R7";
            send_bits(0, 15);
            idle_expect("R7 recovery after flag", 1'b1, 1'b0);
            tag = "R8";
        end

        // R7: corrupted state 15 with the last key bit gives no match
        tag = "R7";
        send_bits(0, 13);
        step(KEY[1], 1'b1, 5'b00001);
        step(KEY[0], 1'b1, 5'b0);
        idle_expect("R7 no match from bad code", 1'b0, 1'b1);

        // R2/R8: two-bit mask from idle lands on legal state 1
        tag = "R2";
        step(1'b0, 1'b0, 5'b00011);
        step(1'b0, 1'b0, 5'b0);
        idle_expect("R8 double flip unflagged", 1'b0, 1'b0);
        send_bits(1, 15);
        idle_expect("R2 double flip reached state one", 1'b1, 1'b0);

        // R9: random stream without faults, key inserted periodically
        tag = "R9";
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 300 == 0) send_bits(0, 15);
            step(lfsr[0], lfsr[3] | lfsr[5], 5'b0);
        end

        // R7/R8: random stream with occasional injected faults
        tag = "R8";
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 250 == 0) send_bits(0, 15);
            step(lfsr[0], lfsr[3] | lfsr[5],
                 (lfsr[15:11] == 5'd0) ? 5'(1 << (int'(lfsr[9:7]) % 5)) : 5'b0);
        end
        step(1'b0, 1'b0, 5'b0);
        step(1'b0, 1'b0, 5'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule